// File: doc/BRIEF.md
# Indirect Command-Word Register Bridge

This block sits between a host processor and the small internal register file of a two-wire serial bus controller. The host does not address the internal registers directly. It writes one 64-bit command word that packs a go flag, an operation code, a direction flag, a three-bit internal address and a data byte. The bridge holds the word, spends a fixed number of cycles on the internal access, and then clears the go flag. When the access was a read, the bridge places the fetched byte in the low byte of the same word. Software launches an operation, polls the word until bit 63 drops, and then picks up any result from bits 7:0.

The internal register file stands in for the serial bus engine, which is outside this block. It holds a data byte, a control byte, a clock-control byte, a status byte and a clock high-phase divider. The configuration bytes are driven out to the engine, and the engine can load a new status value through a small update port. A soft-reset write returns the engine model to its idle status.

Top module: `cmdword_bridge`

## Requirements
- R1: After synchronous reset the host read word is all zeros, the control, clock-control and divider outputs are zero, and the status register holds the idle code 0xF8.
- R2: A host write with bit 63 set, accepted while bit 63 reads 0, makes bit 63 read 1 for exactly ACC_LAT cycles (default 4). It then reads 0, and the access completes on the clock edge that clears it.
- R3: A host write that arrives while bit 63 reads 1 is ignored: the stored word, the access that completes and the internal registers are not changed by it.
- R4: A host write with bit 63 clear, accepted while idle, stores the word's defined fields for readback but performs no internal access.
- R5: Opcode 0x6 (bits 60:57) with bit 56 = 0 writes the low byte to the internal register selected by bits 34:32: 1 is data, 2 is control, 3 is clock control. The low byte of the word keeps the written value.
- R6: Opcode 0x6 with bit 56 = 1 replaces the low byte with the internal register selected by bits 34:32: 1 is data, 2 is control, 3 is status. Addresses 0, 4, 5 and 6 return 0x00.
- R7: Opcode 0x4 with bit 56 = 0 loads the low byte into the clock high-phase divider output and leaves the internal register file untouched.
- R8: An opcode 0x6 write to address 7 clears the data and control registers and sets status to 0xF8. Clock control and the divider keep their values.
- R9: Any opcode other than 0x6 or 0x4 completes after the same latency and performs no internal access.
- R10: Bits 62 and 61 are stored and read back but have no effect. All bits other than 63:56, 34:32 and 7:0 read as zero.
- R11: A status update pulse from the engine loads the status register on the next edge, unless a soft-reset write completes on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wr_data | input | 64 | Command word written by the host |
| host_rd_data | output | 64 | Current command word as seen by the host |
| eng_stat_we | input | 1 | Engine status update strobe |
| eng_stat | input | 8 | Engine status value |
| cfg_ctl | output | 8 | Control byte driven to the engine |
| cfg_clkctl | output | 8 | Clock-control byte driven to the engine |
| cfg_thp | output | 8 | Clock high-phase divider driven to the engine |

## Verification
On every cycle the assertions check that the go flag stays high until the latency counter expires and falls only at the access edge. They also check that a write arriving while busy leaves the opcode, address and direction fields alone, that a soft reset leaves the engine idle with data and control cleared, and that divider and status updates land one edge later. Other behaviours show up only in the bench's scenarios. These are the exact latency seen from the host, the value a read places in the low byte for each address, the way status and clock control share one address, and the fact that an idle write without the go flag, or an unknown opcode, never reaches the register file.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int WORD_W = 64;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int OP_W   = 4;

    localparam int GO_BIT  = 63;
    localparam int SLO_BIT = 62;
    localparam int EIA_BIT = 61;
    localparam int OP_LSB  = 57;
    localparam int RD_BIT  = 56;
    localparam int IA_LSB  = 32;

    localparam logic [OP_W-1:0]   OP_EXT = 4'h6;
    localparam logic [OP_W-1:0]   OP_CLK = 4'h4;

    localparam logic [ADDR_W-1:0] IA_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] IA_CTL  = 3'd2;
    localparam logic [ADDR_W-1:0] IA_CLK  = 3'd3;
    localparam logic [ADDR_W-1:0] IA_RST  = 3'd7;

    localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hF8;

    // Bits of the stored word that read back (go flag is added separately)
    localparam logic [WORD_W-1:0] KEEP_MASK = 64'h7F00_0007_0000_00FF;
endpackage

// File: rtl/bridge_seq.sv
module bridge_seq #(
    parameter int ACC_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic fire
);
    localparam int CW = $clog2(ACC_LAT + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (launch) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(ACC_LAT - 1);
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign fire = st_q.busy && (st_q.cnt == '0);

    // R2: go flag held while the countdown runs
    a_r2_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.cnt != '0) |=> st_q.busy);
    // R2: go flag only drops on the edge where the access fires
    a_r2_fall_at_fire: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.busy) |-> $past(fire));
endmodule

// File: rtl/bridge_decode.sv
module bridge_decode
    import bridge_pkg::*;
(
    input  logic            fire,
    input  logic [OP_W-1:0] op,
    input  logic            rd,
    output logic            ext_wr,
    output logic            ext_rd,
    output logic            clk_wr
);
    always_comb begin
        ext_wr = 1'b0;
        ext_rd = 1'b0;
        clk_wr = 1'b0;
        if (fire) begin
            unique case (op)
                OP_EXT: begin
                    ext_wr = !rd;
                    ext_rd = rd;
                end
                OP_CLK: clk_wr = !rd;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bridge_regfile.sv
module bridge_regfile
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              thp_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              eng_stat_we,
    input  logic [BYTE_W-1:0] eng_stat,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] cfg_ctl,
    output logic [BYTE_W-1:0] cfg_clkctl,
    output logic [BYTE_W-1:0] cfg_thp
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] ctl;
        logic [BYTE_W-1:0] clkctl;
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] thp;
    } rf_t;

    rf_t rf_q, rf_d;
    logic soft_rst;

    assign soft_rst = wr_en && (addr == IA_RST);

    always_comb begin
        rf_d = rf_q;
        if (eng_stat_we) rf_d.stat = eng_stat;
        if (wr_en) begin
            case (addr)
                IA_DATA: rf_d.data   = wdata;
                IA_CTL:  rf_d.ctl    = wdata;
                IA_CLK:  rf_d.clkctl = wdata;
                IA_RST: begin
                    rf_d.data = '0;
                    rf_d.ctl  = '0;
                    rf_d.stat = STAT_IDLE;
                end
                default: ;
            endcase
        end
        if (thp_we) rf_d.thp = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q      <= '0;
            rf_q.stat <= STAT_IDLE;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        case (addr)
            IA_DATA: rdata = rf_q.data;
            IA_CTL:  rdata = rf_q.ctl;
            IA_CLK:  rdata = rf_q.stat;
            default: rdata = '0;
        endcase
    end

    assign cfg_ctl    = rf_q.ctl;
    assign cfg_clkctl = rf_q.clkctl;
    assign cfg_thp    = rf_q.thp;

    // R8: soft reset leaves the engine idle with data and control cleared
    a_r8_soft_reset_idle: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (rf_q.stat == STAT_IDLE && rf_q.data == '0 && rf_q.ctl == '0));
    // R7: divider loads the written byte
    a_r7_thp_load: assert property (@(posedge clk) disable iff (rst)
        thp_we |=> (cfg_thp == $past(wdata)));
    // R11: engine status update lands next edge unless soft reset wins
    a_r11_stat_update: assert property (@(posedge clk) disable iff (rst)
        (eng_stat_we && !soft_rst) |=> (rf_q.stat == $past(eng_stat)));
    // R9: never both kinds of write at once
    a_r9_one_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && thp_we));
endmodule

// File: rtl/cmdword_bridge.sv
module cmdword_bridge
    import bridge_pkg::*;
#(
    parameter int ACC_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_data,
    output logic [WORD_W-1:0] host_rd_data,
    input  logic              eng_stat_we,
    input  logic [BYTE_W-1:0] eng_stat,
    output logic [BYTE_W-1:0] cfg_ctl,
    output logic [BYTE_W-1:0] cfg_clkctl,
    output logic [BYTE_W-1:0] cfg_thp
);
    logic [WORD_W-1:0] cmd_q, cmd_d;
    logic              busy, fire, accept, launch;
    logic              ext_wr, ext_rd, clk_wr;
    logic [BYTE_W-1:0] rf_rdata;
    logic [OP_W-1:0]   op_f;
    logic [ADDR_W-1:0] ia_f;
    logic              rd_f;

    assign accept = host_wr_en && !busy;
    assign launch = accept && host_wr_data[GO_BIT];

    assign op_f = cmd_q[OP_LSB +: OP_W];
    assign ia_f = cmd_q[IA_LSB +: ADDR_W];
    assign rd_f = cmd_q[RD_BIT];

    bridge_seq #(.ACC_LAT(ACC_LAT)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (busy),
        .fire   (fire)
    );

    bridge_decode u_dec (
        .fire   (fire),
        .op     (op_f),
        .rd     (rd_f),
        .ext_wr (ext_wr),
        .ext_rd (ext_rd),
        .clk_wr (clk_wr)
    );

    bridge_regfile u_rf (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (ext_wr),
        .thp_we      (clk_wr),
        .addr        (ia_f),
        .wdata       (cmd_q[BYTE_W-1:0]),
        .eng_stat_we (eng_stat_we),
        .eng_stat    (eng_stat),
        .rdata       (rf_rdata),
        .cfg_ctl     (cfg_ctl),
        .cfg_clkctl  (cfg_clkctl),
        .cfg_thp     (cfg_thp)
    );

    always_comb begin
        cmd_d = cmd_q;
        if (accept)      cmd_d = host_wr_data;
        else if (ext_rd) cmd_d[BYTE_W-1:0] = rf_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    assign host_rd_data = (cmd_q & KEEP_MASK) | ({{(WORD_W-1){1'b0}}, busy} << GO_BIT);

    // R3: a write during busy leaves the decoded fields alone
    a_r3_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr_en) |=> ($stable(op_f) && $stable(ia_f) && $stable(rd_f)));
    // R2: an accepted go write is visible as busy on the next cycle
    a_r2_launch_busy: assert property (@(posedge clk) disable iff (rst)
        launch |=> host_rd_data[GO_BIT]);
    // R4: an idle write without the go flag never starts an access
    a_r4_no_go_idle: assert property (@(posedge clk) disable iff (rst)
        (accept && !host_wr_data[GO_BIT]) |=> !host_rd_data[GO_BIT]);
endmodule

// File: tb/tb_cmdword_bridge.sv
module tb_cmdword_bridge;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [63:0] host_wr_data = '0;
    logic [63:0] host_rd_data;
    logic        eng_stat_we = 1'b0;
    logic [7:0]  eng_stat = '0;
    logic [7:0]  cfg_ctl, cfg_clkctl, cfg_thp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cmdword_bridge #(.ACC_LAT(LAT)) dut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_data(host_rd_data),
        .eng_stat_we(eng_stat_we), .eng_stat(eng_stat),
        .cfg_ctl(cfg_ctl), .cfg_clkctl(cfg_clkctl), .cfg_thp(cfg_thp)
    );

    function automatic logic [63:0] mkw(bit go, bit slo, bit eia, logic [3:0] op,
                                        bit r, logic [2:0] ia, logic [7:0] d);
        logic [63:0] w = '0;
        w[63] = go; w[62] = slo; w[61] = eia; w[60:57] = op;
        w[56] = r;  w[34:32] = ia; w[7:0] = d;
        return w;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops an expectation each time the go flag falls
    bit prev_v = 1'b0;
    always @(negedge clk) begin
        if (!rst && prev_v && !host_rd_data[63]) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected completion", host_rd_data, 64'h0);
            end else begin
                check(tag_q.pop_front(), host_rd_data, exp_q.pop_front());
            end
        end
        prev_v = host_rd_data[63];
    end

    // Driver: push expectation, launch, optionally intrude while busy
    task automatic run_cmd(string tag, logic [63:0] word, logic [63:0] exp,
                           bit intr = 1'b0, logic [63:0] iword = '0);
        int n = 0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = word;
        @(negedge clk);
        host_wr_en = 1'b0;
        while (host_rd_data[63] && n < 50) begin
            n++;
            host_wr_en   = intr && (n == 1);
            host_wr_data = iword;
            @(negedge clk);
        end
        host_wr_en = 1'b0;
        check({"R2 latency ", tag}, 64'(n), 64'(LAT));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 word", host_rd_data, 64'h0);
        check("R1 cfg", {40'h0, cfg_ctl, cfg_clkctl, cfg_thp}, 64'h0);
        run_cmd("R1 status idle", mkw(1,0,0,4'h6,1,3'd3,8'h00), mkw(0,0,0,4'h6,1,3'd3,8'hF8));

        // R5 data write, R6 readback replaces low byte
        run_cmd("R5 data write", mkw(1,0,0,4'h6,0,3'd1,8'h5A), mkw(0,0,0,4'h6,0,3'd1,8'h5A));
        run_cmd("R6 data read", mkw(1,0,0,4'h6,1,3'd1,8'hEE), mkw(0,0,0,4'h6,1,3'd1,8'h5A));
        run_cmd("R5 ctl write", mkw(1,0,0,4'h6,0,3'd2,8'h44), mkw(0,0,0,4'h6,0,3'd2,8'h44));
        check("R5 cfg_ctl", 64'(cfg_ctl), 64'h44);
        run_cmd("R6 ctl read", mkw(1,0,0,4'h6,1,3'd2,8'h00), mkw(0,0,0,4'h6,1,3'd2,8'h44));
        run_cmd("R5 clkctl write", mkw(1,0,0,4'h6,0,3'd3,8'h2B), mkw(0,0,0,4'h6,0,3'd3,8'h2B));
        check("R5 cfg_clkctl", 64'(cfg_clkctl), 64'h2B);
        run_cmd("R6 addr3 reads status", mkw(1,0,0,4'h6,1,3'd3,8'h00), mkw(0,0,0,4'h6,1,3'd3,8'hF8));
        run_cmd("R6 unassigned read", mkw(1,0,0,4'h6,1,3'd5,8'h99), mkw(0,0,0,4'h6,1,3'd5,8'h00));

        // R7 clock opcode
        run_cmd("R7 thp write", mkw(1,0,0,4'h4,0,3'd0,8'h18), mkw(0,0,0,4'h4,0,3'd0,8'h18));
        check("R7 cfg_thp", 64'(cfg_thp), 64'h18);
        check("R7 clkctl untouched", 64'(cfg_clkctl), 64'h2B);

        // R11 engine status update
        @(negedge clk);
        eng_stat_we = 1'b1; eng_stat = 8'h28;
        @(negedge clk);
        eng_stat_we = 1'b0;
        run_cmd("R11 status read", mkw(1,0,0,4'h6,1,3'd3,8'h00), mkw(0,0,0,4'h6,1,3'd3,8'h28));

        // R8 soft reset
        run_cmd("R8 soft reset", mkw(1,0,0,4'h6,0,3'd7,8'h00), mkw(0,0,0,4'h6,0,3'd7,8'h00));
        run_cmd("R8 status idle", mkw(1,0,0,4'h6,1,3'd3,8'h00), mkw(0,0,0,4'h6,1,3'd3,8'hF8));
        run_cmd("R8 data cleared", mkw(1,0,0,4'h6,1,3'd1,8'hAA), mkw(0,0,0,4'h6,1,3'd1,8'h00));
        check("R8 ctl cleared", 64'(cfg_ctl), 64'h00);
        check("R8 clock kept", {48'h0, cfg_clkctl, cfg_thp}, {48'h0, 8'h2B, 8'h18});

        // R3 write during busy ignored
        run_cmd("R3 busy ignore", mkw(1,0,0,4'h6,1,3'd2,8'h00), mkw(0,0,0,4'h6,1,3'd2,8'h00),
                1'b1, mkw(1,0,0,4'h6,0,3'd2,8'h11));
        repeat (LAT + 2) @(negedge clk);
        check("R3 no late launch", {56'h0, cfg_ctl}, 64'h00);
        check("R3 idle after", 64'(host_rd_data[63]), 64'h0);

        // R10 spare bits stored, undefined bits read zero
        run_cmd("R10 spare bits", mkw(1,1,1,4'h6,0,3'd2,8'h33) | 64'h00FF_FFF8_FFFF_FF00,
                mkw(0,1,1,4'h6,0,3'd2,8'h33));
        check("R10 ctl written", 64'(cfg_ctl), 64'h33);

        // R4 write without go flag
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = mkw(0,0,0,4'h6,0,3'd2,8'h55);
        @(negedge clk);
        host_wr_en = 1'b0;
        check("R4 stored fields", host_rd_data, mkw(0,0,0,4'h6,0,3'd2,8'h55));
        repeat (LAT + 2) @(negedge clk);
        check("R4 no access", 64'(cfg_ctl), 64'h33);

        // R9 unknown opcode
        run_cmd("R9 unknown op", mkw(1,0,0,4'h3,0,3'd2,8'h77), mkw(0,0,0,4'h3,0,3'd2,8'h77));
        check("R9 ctl untouched", 64'(cfg_ctl), 64'h33);
        run_cmd("R9 read unknown op", mkw(1,0,0,4'h9,1,3'd2,8'h66), mkw(0,0,0,4'h9,1,3'd2,8'h66));

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule